// File: doc/BRIEF.md
# Interleaved Converter Sample Combiner

This block is the digital back end of a converter built from four identical 10-bit sub-converters. All four run at the same reference rate, and their sampling clocks are offset from one another by a quarter of the reference period. The phases are named a, b, c and d. The block runs on a clock four times the reference rate. Inputs are synchronised to this clock, and phase k presents its sample with a valid strobe in slot k of a repeating four-cycle frame. From that frame the block emits at most one sample per fast cycle, together with a 2-bit channel tag, a valid flag and a flag that marks the first frame after a mode switch.

The channel tag depends on the selected grouping. In quad mode the four sub-converters are separate channels at the base rate. In pair mode, phases a and c merge into channel 0 and phases b and d merge into channel 1, so each channel is sampled at twice the base rate with even spacing. In mono mode all four phases merge into one channel at four times the base rate. A new grouping is only adopted between frames, and the frame alignment never moves. A sticky error bit records a strobe that is missing from its slot or that appears in a slot that is not its own.

Top module: `ilv_sample_combiner`

## Requirements
- R1: During reset, and on the first cycle after it is released, outValid, outErr and outFrameFlag are 0. After reset the frame starts at phase a and the grouping is quad mode.
- R2: The sample that phase k (a=0, b=1, c=2, d=3) presents in slot k of the frame appears on outData with outValid high exactly one fast cycle later. Every mode emits the phases in the order a, b, c, d.
- R3: In quad mode (modeReq code 2'b00), outTag equals the phase index.
- R4: In pair mode (code 2'b01), phases a and c carry tag 0 and phases b and d carry tag 1.
- R5: In mono mode (code 2'b10), every sample carries tag 0.
- R6: modeReq is sampled only in the slot of phase d. A change takes effect from the next phase a sample, and a value that is present only in other slots has no effect.
- R7: outFrameFlag is high on all four outputs of the first frame after the grouping changes, and low otherwise. Requesting the current mode again does not raise it.
- R8: The reserved code 2'b11 is ignored at the frame boundary, and the previous grouping stays in force.
- R9: If phase k's strobe is low in slot k, that slot's output has outValid low, outErr is set, and the following slots keep their alignment.
- R10: A strobe from a sub-converter outside its own slot sets outErr and does not change the data, tag or valid flag of that slot.
- R11: outErr stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the reference rate |
| rstN | input | 1 | Active-low synchronous reset |
| modeReq | input | 2 | Requested grouping: 00 quad, 01 pair, 10 mono, 11 reserved |
| adcValid | input | 4 | Per-phase sample strobe, bit k for phase k |
| adcData | input | 40 | Per-phase samples, phase k in bits [10k+9:10k] |
| outValid | output | 1 | Output sample is valid |
| outData | output | 10 | Output sample |
| outTag | output | 2 | Channel number of the output sample |
| outFrameFlag | output | 1 | Sample belongs to the first frame after a mode change |
| outErr | output | 1 | Sticky strobe-error flag |

## Verification
Every slot gets a fresh random sample on each of the four lanes. A phase that is routed to the wrong slot, or an output one cycle off, therefore shows up as a data mismatch, not an accidental match. Runs in quad, pair and mono mode tell the three tag maps apart. A mode request raised in the middle of a frame, and one that is present in every slot except phase d, separate adoption only at the boundary from adoption on any cycle. A re-request of the active mode and the reserved code separate a real change from no change. A dropped strobe and a stray strobe separate the underrun and overrun paths, and both show whether later slots keep their alignment and whether the error bit stays set.

// File: rtl/ilv_comb_pkg.sv
package ilv_comb_pkg;
  localparam int PHASES = 4;
  localparam int SLOT_W = $clog2(PHASES);
  localparam int TAG_W  = 2;

  typedef enum logic [1:0] {
    MODE_QUAD = 2'b00,
    MODE_PAIR = 2'b01,
    MODE_MONO = 2'b10,
    MODE_RSVD = 2'b11
  } combMode_e;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    combMode_e         mode;
    logic              freshFrame;
  } combStrobe_t;
endpackage

// File: rtl/ilv_comb_ctrl.sv
module ilv_comb_ctrl
  import ilv_comb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeReq,
  output combStrobe_t strobe
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PHASES - 1);

  logic [SLOT_W-1:0] slotQ;
  combMode_e         modeQ;
  logic              freshQ;
  logic              frameEnd;
  logic              acceptReq;
  combMode_e         reqMode;

  assign reqMode   = combMode_e'(modeReq);
  assign frameEnd  = (slotQ == LAST_SLOT);
  assign acceptReq = (reqMode != MODE_RSVD) && (reqMode != modeQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ  <= '0;
      modeQ  <= MODE_QUAD;
      freshQ <= 1'b0;
    end else begin
      slotQ <= frameEnd ? '0 : slotQ + 1'b1;
      if (frameEnd) begin
        freshQ <= acceptReq;
        if (acceptReq) modeQ <= reqMode;
      end
    end
  end

  always_comb begin
    strobe.slot       = slotQ;
    strobe.mode       = modeQ;
    strobe.freshFrame = freshQ;
  end
endmodule

// File: rtl/ilv_comb_datapath.sv
module ilv_comb_datapath
  import ilv_comb_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  combStrobe_t                strobe,
  input  logic [PHASES-1:0]          adcValid,
  input  logic [PHASES*SAMPLE_W-1:0] adcData,
  output logic                       outValid,
  output logic [SAMPLE_W-1:0]        outData,
  output logic [TAG_W-1:0]           outTag,
  output logic                       outFrameFlag,
  output logic                       outErr
);
  logic [SAMPLE_W-1:0] lane [PHASES];
  logic [PHASES-1:0]   slotHot;
  logic                slotValid;
  logic                missing;
  logic                stray;
  logic [TAG_W-1:0]    tagNext;

  for (genvar p = 0; p < PHASES; p++) begin : g_lane
    assign lane[p]    = adcData[p*SAMPLE_W +: SAMPLE_W];
    assign slotHot[p] = (strobe.slot == SLOT_W'(p));
  end

  assign slotValid = |(adcValid & slotHot);
  assign missing   = !slotValid;
  assign stray     = |(adcValid & ~slotHot);

  always_comb begin
    unique case (strobe.mode)
      MODE_PAIR: tagNext = TAG_W'(strobe.slot[0]);
      MODE_MONO: tagNext = '0;
      default:   tagNext = TAG_W'(strobe.slot);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outData      <= '0;
      outTag       <= '0;
      outFrameFlag <= 1'b0;
      outErr       <= 1'b0;
    end else begin
      outValid     <= slotValid;
      outData      <= lane[strobe.slot];
      outTag       <= tagNext;
      outFrameFlag <= strobe.freshFrame;
      outErr       <= outErr | missing | stray;
    end
  end
endmodule

// File: rtl/ilv_sample_combiner.sv
module ilv_sample_combiner
  import ilv_comb_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 modeReq,
  input  logic [PHASES-1:0]          adcValid,
  input  logic [PHASES*SAMPLE_W-1:0] adcData,
  output logic                       outValid,
  output logic [SAMPLE_W-1:0]        outData,
  output logic [TAG_W-1:0]           outTag,
  output logic                       outFrameFlag,
  output logic                       outErr
);
  combStrobe_t strobe;

  ilv_comb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeReq (modeReq),
    .strobe  (strobe)
  );

  ilv_comb_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .adcValid     (adcValid),
    .adcData      (adcData),
    .outValid     (outValid),
    .outData      (outData),
    .outTag       (outTag),
    .outFrameFlag (outFrameFlag),
    .outErr       (outErr)
  );
endmodule

// File: rtl/ilv_comb_checker.sv
module ilv_comb_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] adcValid,
  input logic       outValid,
  input logic [1:0] outTag,
  input logic       outFrameFlag,
  input logic       outErr,
  input logic [1:0] activeMode,
  input logic [1:0] slot
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && !outErr && !outFrameFlag)); // R1

  AST_NO_STROBE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|adcValid) |-> !outValid); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    outErr |=> outErr); // R11

  AST_MONO_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(activeMode) == 2'b10) |-> (outTag == 2'b00)); // R5

  AST_PAIR_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(activeMode) == 2'b01) |-> (outTag[1] == 1'b0)); // R4

  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (slot != 2'd3) |=> $stable(activeMode)); // R6

  AST_NO_RSVD_MODE: assert property (@(posedge clk) disable iff (!rstN)
    activeMode != 2'b11); // R8
endmodule

bind ilv_sample_combiner ilv_comb_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .adcValid     (adcValid),
  .outValid     (outValid),
  .outTag       (outTag),
  .outFrameFlag (outFrameFlag),
  .outErr       (outErr),
  .activeMode   (strobe.mode),
  .slot         (strobe.slot)
);

// File: tb/tb_ilv_sample_combiner.sv
`timescale 1ns/1ps
module tb_ilv_sample_combiner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeReq = 2'b00;
  logic [3:0]  adcValid = '0;
  logic [39:0] adcData = '0;
  logic        outValid;
  logic [9:0]  outData;
  logic [1:0]  outTag;
  logic        outFrameFlag;
  logic        outErr;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic       v;
    logic [9:0] d;
    logic [1:0] t;
    logic       f;
    logic       e;
    string      note;
  } item_t;

  item_t q[$];

  int         benchSlot = 0;
  logic [1:0] expMode = 2'b00;
  logic       expFresh = 1'b0;
  logic       expErr = 1'b0;
  string      note = "";

  always #2.5 clk = ~clk;

  ilv_sample_combiner dut (
    .clk(clk), .rstN(rstN), .modeReq(modeReq), .adcValid(adcValid),
    .adcData(adcData), .outValid(outValid), .outData(outData),
    .outTag(outTag), .outFrameFlag(outFrameFlag), .outErr(outErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: one slot per fast cycle, expected result pushed to the scoreboard
  task automatic driveSlot(input logic [3:0] vmask, input logic [1:0] req);
    item_t it;
    logic [39:0] d;
    @(negedge clk);
    rstN = 1'b1;
    for (int p = 0; p < 4; p++) d[p*10 +: 10] = 10'($urandom);
    adcData  = d;
    adcValid = vmask;
    modeReq  = req;
    it.v = vmask[benchSlot];
    it.d = d[benchSlot*10 +: 10];
    case (expMode)
      2'b01:   it.t = 2'(benchSlot & 1);
      2'b10:   it.t = 2'b00;
      default: it.t = 2'(benchSlot);
    endcase
    it.f = expFresh;
    expErr = expErr | !vmask[benchSlot] | |(vmask & ~(4'b0001 << benchSlot));
    it.e = expErr;
    it.note = $sformatf("%s mode=%0d slot=%0d", note, expMode, benchSlot);
    q.push_back(it);
    if (benchSlot == 3) begin
      if (req != 2'b11 && req != expMode) begin
        expMode  = req;
        expFresh = 1'b1;
      end else begin
        expFresh = 1'b0;
      end
    end
    benchSlot = (benchSlot + 1) % 4;
  endtask

  task automatic driveFrames(input int n, input logic [1:0] req);
    for (int i = 0; i < n * 4; i++) driveSlot(4'b0001 << benchSlot, req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    adcValid = '0;
    modeReq = 2'b00;
    repeat (3) @(negedge clk);
    q.delete();
    benchSlot = 0;
    expMode = 2'b00;
    expFresh = 1'b0;
    expErr = 1'b0;
    check(outValid == 1'b0, "R1", "reset outValid", outValid, 0);
    check(outErr == 1'b0, "R1", "reset outErr", outErr, 0);
    check(outFrameFlag == 1'b0, "R1", "reset outFrameFlag", outFrameFlag, 0);
  endtask

  // monitor: pops and compares one item per cycle after the capturing edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (rstN && q.size() > 0) begin
        it = q.pop_front();
        check(outValid === it.v, it.v ? "R2" : "R9",
              {"valid ", it.note}, outValid, it.v);
        if (it.v) begin
          check(outData === it.d, "R2", {"data ", it.note}, outData, it.d);
          check(outTag === it.t, "R3 R4 R5", {"tag ", it.note}, outTag, it.t);
        end
        check(outFrameFlag === it.f, "R7", {"frame flag ", it.note},
              outFrameFlag, it.f);
        check(outErr === it.e, "R9 R10 R11", {"err ", it.note}, outErr, it.e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    doReset();                         // R1
    note = "R1 R3 quad default";
    driveFrames(3, 2'b00);

    note = "R6 mid-frame request";     // pair requested from slot b onward
    driveSlot(4'b0001, 2'b00);
    driveSlot(4'b0010, 2'b01);
    driveSlot(4'b0100, 2'b01);
    driveSlot(4'b1000, 2'b01);
    note = "R4 R7 pair";
    driveFrames(3, 2'b01);

    note = "R7 same mode again";
    driveFrames(2, 2'b01);

    note = "R8 reserved ignored";
    driveFrames(2, 2'b11);

    note = "R5 R7 mono";
    driveFrames(3, 2'b10);

    note = "R6 request absent at phase d";
    driveSlot(4'b0001, 2'b00);
    driveSlot(4'b0010, 2'b00);
    driveSlot(4'b0100, 2'b00);
    driveSlot(4'b1000, 2'b10);
    driveFrames(1, 2'b10);

    note = "R9 missing strobe";
    driveSlot(4'b0001, 2'b10);
    driveSlot(4'b0000, 2'b10);
    driveSlot(4'b0100, 2'b10);
    driveSlot(4'b1000, 2'b10);
    note = "R11 sticky error";
    driveFrames(2, 2'b00);

    doReset();                         // R1 R11 reset clears error
    note = "R10 stray strobe";
    driveSlot(4'b0011, 2'b00);
    driveSlot(4'b0010, 2'b00);
    driveSlot(4'b1100, 2'b00);
    driveSlot(4'b1000, 2'b00);
    note = "R11 sticky after stray";
    driveFrames(2, 2'b01);

    @(negedge clk);
    adcValid = '0;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule